// File: doc/BRIEF.md
# Segmented DAC Code and Correction Path

This block sits between the digital input of a self-calibrated voltage DAC and its analog switch array. Each clock it takes one 16-bit code and splits it: the four most significant bits become fifteen equal-weight enable lines, in thermometer form. The twelve lower bits drive the binary-weighted section unchanged. At the same time the six most significant bits index a 64-entry correction memory. The word read from that memory goes to a separate correction DAC, whose current is added to the main DAC current by the analog summing stage.

A calibration sequencer fills the correction memory through a synchronous write port. While calibrating, it takes over the main code path with a code of its own and can switch on the spare half-step element of the main DAC. A clear input parks the output at the zero-scale code in unipolar operation, or at midscale in bipolar operation. All outputs leave from one register stage, so the main code and its correction always change on the same edge.

Top module: `segdac_corr_path`

## Requirements
- R1: With the selected code's top four bits equal to n, `seg_on` bits n-1 down to 0 are 1 and bits 14 down to n are 0. n=0 gives all zeros and n=15 gives all fifteen lines on.
- R2: `bin_on` bit i equals bit i of the selected code, for i = 0 to 11.
- R3: `corr_code` equals the memory entry addressed by bits 15 to 10 of the selected code.
- R4: Input values sampled at a rising edge appear on all four outputs together, right after that edge. This is one register stage with no extra delay on any output.
- R5: When `wr_en` is 1 at a rising edge, `wr_data` is stored at `wr_addr`. Later reads of that address return it, and other entries keep their contents.
- R6: When a write hits the address being read at the same edge, `corr_code` shows the newly written data.
- R7: With `cal_mode` at 1, the selected code is `cal_code` and `xlsb_on` follows `cal_xlsb`. With `cal_mode` at 0, `data_in` is selected and `xlsb_on` stays 0 whatever `cal_xlsb` is.
- R8: With `clr` at 1 and `bipolar` at 0, the selected code is 0x0000.
- R9: With `clr` at 1 and `bipolar` at 1, the selected code is 0x8000 (MSB only). `clr` takes priority over `cal_mode` and forces `xlsb_on` to 0.
- R10: While `rst_n` is 0, `seg_on`, `bin_on`, `xlsb_on` and `corr_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| data_in | input | 16 | Normal-operation DAC code |
| bipolar | input | 1 | 1 selects bipolar operation, which sets the clear value |
| clr | input | 1 | Forces the zero-scale or midscale code |
| cal_mode | input | 1 | Selects the sequencer code path |
| cal_code | input | 16 | Code supplied by the calibration sequencer |
| cal_xlsb | input | 1 | Spare half-step request from the sequencer |
| wr_en | input | 1 | Correction memory write enable |
| wr_addr | input | 6 | Correction memory write address |
| wr_data | input | 8 | Correction word to store |
| seg_on | output | 15 | Thermometer enables for the equal-weight elements |
| bin_on | output | 12 | Binary section bit controls |
| xlsb_on | output | 1 | Spare half-step element enable |
| corr_code | output | 8 | Code for the correction DAC |

## Verification
The hardest case to reach is a write and a read of the same memory entry at the same edge, while the read address comes from the calibration code path rather than from the user code. In that case the new word has to pass straight through to `corr_code`. The stimulus first fills every entry with a known pattern. It then issues writes whose address matches the top six bits of the code it drives at that same edge, once through `data_in` and once through `cal_code`. It also sweeps all sixteen segment values so that both ends of the thermometer range are covered.

// File: rtl/segdac_corr_path.sv
module segdac_corr_path #(
  parameter int DATA_W    = 16,
  parameter int SEG_BITS  = 4,
  parameter int ADDR_BITS = 6,
  parameter int CORR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DATA_W-1:0]      data_in,
  input  logic                   bipolar,
  input  logic                   clr,
  input  logic                   cal_mode,
  input  logic [DATA_W-1:0]      cal_code,
  input  logic                   cal_xlsb,
  input  logic                   wr_en,
  input  logic [ADDR_BITS-1:0]   wr_addr,
  input  logic [CORR_W-1:0]      wr_data,
  output logic [(2**SEG_BITS)-2:0] seg_on,
  output logic [DATA_W-SEG_BITS-1:0] bin_on,
  output logic                   xlsb_on,
  output logic [CORR_W-1:0]      corr_code
);
  localparam int SEG_N = (2**SEG_BITS) - 1;
  localparam int BIN_W = DATA_W - SEG_BITS;
  localparam int DEPTH = 2**ADDR_BITS;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]    code_sel;
  logic [SEG_BITS-1:0]  top;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [SEG_N-1:0]     seg_d;
  logic                 xlsb_d;
  logic [CORR_W-1:0]    corr_d;
  logic [CORR_W-1:0]    mem [DEPTH];

  assign code_sel = clr ? (bipolar ? MID : '0) : (cal_mode ? cal_code : data_in);
  assign xlsb_d   = !clr && cal_mode && cal_xlsb;
  assign top      = code_sel[DATA_W-1 -: SEG_BITS];
  assign rd_addr  = code_sel[DATA_W-1 -: ADDR_BITS];

  for (genvar i = 0; i < SEG_N; i++) begin : g_therm
    assign seg_d[i] = top > SEG_BITS'(i);
  end

  assign corr_d = (wr_en && wr_addr == rd_addr) ? wr_data : mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_on    <= '0;
      bin_on    <= '0;
      xlsb_on   <= 1'b0;
      corr_code <= '0;
    end else begin
      seg_on    <= seg_d;
      bin_on    <= code_sel[BIN_W-1:0];
      xlsb_on   <= xlsb_d;
      corr_code <= corr_d;
    end
  end
endmodule

module segdac_corr_chk #(
  parameter int DATA_W    = 16,
  parameter int SEG_BITS  = 4,
  parameter int ADDR_BITS = 6,
  parameter int CORR_W    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DATA_W-1:0]        data_in,
  input logic                     bipolar,
  input logic                     clr,
  input logic                     cal_mode,
  input logic                     wr_en,
  input logic [ADDR_BITS-1:0]     wr_addr,
  input logic [CORR_W-1:0]        wr_data,
  input logic [(2**SEG_BITS)-2:0] seg_on,
  input logic [DATA_W-SEG_BITS-1:0] bin_on,
  input logic                     xlsb_on,
  input logic [CORR_W-1:0]        corr_code
);
  localparam int SEG_N = (2**SEG_BITS) - 1;
  localparam int BIN_W = DATA_W - SEG_BITS;
  localparam logic [SEG_N-1:0] HALF = SEG_N'((1 << (2**(SEG_BITS-1))) - 1);

  assert_therm_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_on + 1'b1) & seg_on) == '0);

  assert_bin_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(clr) && !$past(cal_mode) |-> bin_on == $past(data_in[BIN_W-1:0]));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(clr) && !$past(cal_mode) && $past(wr_en) &&
    $past(wr_addr) == $past(data_in[DATA_W-1 -: ADDR_BITS]) |-> corr_code == $past(wr_data));

  assert_xlsb_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_mode) |-> !xlsb_on);

  assert_clr_uni_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clr) && !$past(bipolar) |-> seg_on == '0 && bin_on == '0);

  assert_clr_bip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clr) && $past(bipolar) |-> seg_on == HALF && bin_on == '0 && !xlsb_on);
endmodule

bind segdac_corr_path segdac_corr_chk #(
  .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .ADDR_BITS(ADDR_BITS), .CORR_W(CORR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .bipolar(bipolar), .clr(clr),
  .cal_mode(cal_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .seg_on(seg_on), .bin_on(bin_on), .xlsb_on(xlsb_on), .corr_code(corr_code)
);

// File: tb/segdac_corr_path_tb_top.sv
`timescale 1ns/1ps
module segdac_corr_path_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] data_in = '0, cal_code = '0;
  logic bipolar = 0, clr = 0, cal_mode = 0, cal_xlsb = 0, wr_en = 0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [14:0] seg_on;
  logic [11:0] bin_on;
  logic xlsb_on;
  logic [7:0] corr_code;

  always #2.5 clk = ~clk;

  segdac_corr_path dut_i (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .bipolar(bipolar), .clr(clr),
    .cal_mode(cal_mode), .cal_code(cal_code), .cal_xlsb(cal_xlsb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .seg_on(seg_on), .bin_on(bin_on),
    .xlsb_on(xlsb_on), .corr_code(corr_code)
  );

  typedef struct {
    bit chk; string req;
    logic [14:0] seg; logic [11:0] bin; logic xl; logic [7:0] corr;
  } item_t;

  item_t q[$];
  logic [7:0] shadow [64];
  int errors = 0, checks = 0;

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic bip, input logic cl,
                       input logic cm, input logic [15:0] cc, input logic cx,
                       input logic we, input logic [5:0] wa, input logic [7:0] wd,
                       input bit chk, input string req);
    item_t it;
    logic [15:0] code;
    @(negedge clk);
    data_in = d; bipolar = bip; clr = cl; cal_mode = cm; cal_code = cc;
    cal_xlsb = cx; wr_en = we; wr_addr = wa; wr_data = wd;
    code = cl ? (bip ? 16'h8000 : 16'h0000) : (cm ? cc : d);
    it.chk = chk; it.req = req;
    it.seg = '0;
    for (int i = 0; i < 15; i++) if (i < int'(code[15:12])) it.seg[i] = 1'b1;
    it.bin = code[11:0];
    it.xl = cm && cx && !cl;
    it.corr = (we && wa == code[15:10]) ? wd : shadow[code[15:10]];
    if (we) shadow[wa] = wd;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) begin
        expect_eq(it.req, "seg_on", 32'(seg_on), 32'(it.seg));
        expect_eq(it.req, "bin_on", 32'(bin_on), 32'(it.bin));
        expect_eq(it.req, "xlsb_on", 32'(xlsb_on), 32'(it.xl));
        expect_eq(it.req, "corr_code", 32'(corr_code), 32'(it.corr));
      end
    end
  end

  task automatic idle(input logic [15:0] d, input bit chk, input string req);
    apply(d, 0, 0, 0, 16'h0, 0, 0, 6'h0, 8'h0, chk, req);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    expect_eq("R10", "seg_on", 32'(seg_on), 0);
    expect_eq("R10", "bin_on", 32'(bin_on), 0);
    expect_eq("R10", "xlsb_on", 32'(xlsb_on), 0);
    expect_eq("R10", "corr_code", 32'(corr_code), 0);
    rst_n = 1'b1;
    // R5: fill memory
    for (int a = 0; a < 64; a++)
      apply(16'h0, 0, 0, 0, 16'h0, 0, 1, 6'(a), 8'(a * 7 + 3), 0, "R5");
    // R1 R2 R3 R4: sweep all segment values
    for (int n = 0; n < 16; n++)
      idle(16'((n << 12) | (n * 16'h0111 & 16'h0fff) | 16'h0400), 1, "R1");
    idle(16'hffff, 1, "R1");
    idle(16'h0000, 1, "R1");
    idle(16'h0a5c, 1, "R2");
    idle(16'hf3a1, 1, "R3");
    idle(16'h5555, 1, "R4");
    idle(16'haaaa, 1, "R4");
    // R5: rewrite one entry, others kept
    apply(16'h0000, 0, 0, 0, 16'h0, 0, 1, 6'd20, 8'hc3, 1, "R5");
    idle(16'h5000, 1, "R5");
    idle(16'h5400, 1, "R5");
    // R6: same-edge write/read, user path and calibration path
    apply(16'h7c21, 0, 0, 0, 16'h0, 0, 1, 6'h1f, 8'h9e, 1, "R6");
    idle(16'h7c00, 1, "R6");
    apply(16'h0000, 0, 0, 1, 16'hb802, 0, 1, 6'h2e, 8'h44, 1, "R6");
    // R7: calibration path, spare element
    apply(16'h1234, 0, 0, 1, 16'hc7f0, 1, 0, 6'h0, 8'h0, 1, "R7");
    apply(16'h1234, 0, 0, 1, 16'hc7f0, 0, 0, 6'h0, 8'h0, 1, "R7");
    apply(16'h1234, 0, 0, 0, 16'hc7f0, 1, 0, 6'h0, 8'h0, 1, "R7");
    // R8 R9: clear
    apply(16'hffff, 0, 1, 0, 16'h0, 0, 0, 6'h0, 8'h0, 1, "R8");
    apply(16'hffff, 1, 1, 0, 16'h0, 0, 0, 6'h0, 8'h0, 1, "R9");
    apply(16'h0001, 1, 1, 1, 16'hffff, 1, 0, 6'h0, 8'h0, 1, "R9");
    apply(16'h0001, 0, 1, 1, 16'hffff, 1, 0, 6'h0, 8'h0, 1, "R8");
    idle(16'h9999, 1, "R4");
    @(negedge clk); @(negedge clk);
    // R10: asynchronous reset clears outputs
    rst_n = 1'b0;
    #1;
    expect_eq("R10", "seg_on", 32'(seg_on), 0);
    expect_eq("R10", "bin_on", 32'(bin_on), 0);
    expect_eq("R10", "corr_code", 32'(corr_code), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule